// File: doc/BRIEF.md
# Snoop Broadcast Response Resolver

This block takes one bus request at a time, offers it in turn to each attached port other than the one that issued it, and folds the answers into a single bus outcome. Ports marked as masters by a parameter mask are offered the request first, in ascending index. The remaining ports follow, also in ascending index. One port is offered the request per clock. The first port in that order that answers with a result becomes the responder. A nack from any offered port aborts the transaction so the requester can retry.

When the result is a success or no result, a snoop-complete pulse goes back to the requester. A blocked answer freezes the bus. No new request is taken until the blocking port releases it. Two protocol checks are reported with the outcome: more than one supplier, and no supplier for a read or write. An illegal answer code sets a sticky error flag.

Top module: `snp_resolver`

## Requirements
- R1: After reset, `done`, `poll_valid`, `bus_blocked`, `proto_err`, `err_multi`, `err_none` and `snoop_cmpl` are 0 and `req_ready` is 1.
- R2: An accepted request is offered one slot per cycle. The slot order lists the ports whose `MASTER_MASK` bit is 1, in ascending index, then the other ports in ascending index. Slot 0 is visible in the cycle after acceptance. The requester's own slot still takes a cycle but has `poll_valid` low. Without a nack, `done` rises NPORTS+1 cycles after the accepting edge.
- R3: The first offered port in slot order whose code is 01 (success) or 10 (blocked) is the responder. `done_outcome` is 01 for success, 10 for blocked and 00 for no result. `done_responder` gives the responder index, or 0 when there is no responder.
- R4: The requester's own response code and nack bit never affect the outcome.
- R5: A nack (bit p of `rsp_nack`) from an offered port ends the scan at that slot. `done` follows in the next cycle with outcome 11 (retry). A retry never comes with `snoop_cmpl` and never reports success.
- R6: `err_multi` is high with `done` when two or more offered ports return 01 or 10 and the outcome is not retry.
- R7: `err_none` is high with `done` when no offered port returns a result, no nack occurred, and the command is read (01) or write (10). Commands 00 and 11 never raise it.
- R8: Outcome 10 puts the block in the blocked state. In that state `bus_blocked` is 1, `blocked_id` holds the responder, `req_ready` is 0 and requests are ignored. A release with a different id is ignored. A release from `blocked_id` returns the block to idle at the next edge.
- R9: `snoop_cmpl` pulses with `done` exactly when the outcome is 00 or 01, and `snoop_cmpl_id` carries the requester id.
- R10: Code 11 from an offered port sets `proto_err` and is otherwise treated as no result. `proto_err` is cleared only by reset.
- R11: `done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_id | input | IDW | Requesting port index |
| req_cmd | input | 2 | Command: 00 other, 01 read, 10 write, 11 invalidate |
| req_addr | input | AW | Request address |
| req_ready | output | 1 | Block idle and able to accept |
| poll_valid | output | 1 | The port in `poll_port` is being offered the request |
| poll_port | output | IDW | Port of the current slot |
| poll_cmd | output | 2 | Latched command shown to the polled port |
| poll_addr | output | AW | Latched address shown to the polled port |
| rsp_code | input | 2*NPORTS | Per-port code at bits [2p+1:2p]: 00 none, 01 success, 10 blocked, 11 illegal |
| rsp_nack | input | NPORTS | Per-port nack |
| release_valid | input | 1 | Release strobe for a blocked bus |
| release_id | input | IDW | Port issuing the release |
| done | output | 1 | Outcome valid pulse |
| done_outcome | output | 2 | 00 no result, 01 success, 10 blocked, 11 retry |
| done_responder | output | IDW | Responder index |
| err_multi | output | 1 | More than one supplier |
| err_none | output | 1 | No supplier for read or write |
| snoop_cmpl | output | 1 | Snoop-complete notification to requester |
| snoop_cmpl_id | output | IDW | Requester to notify |
| proto_err | output | 1 | Sticky illegal-code flag |
| bus_blocked | output | 1 | Bus frozen by a blocked answer |
| blocked_id | output | IDW | Port that must release the bus |

## Verification
The hardest cases to reach are those where the winner is decided by slot order rather than by port index. A multi-supplier condition that a later nack must hide is one such case. A blocked bus that only the right port may release is another. The bench holds a static code and nack pattern on every port, including the requester, for each request. The patterns place results and nacks in chosen slots on both sides of the requester. The bench tracks `poll_port` slot by slot against an order it computes from the mask. The blocked state is reached with a blocked code on a master port. It is then probed with ignored requests, a release from the wrong id and a release from the right one.

// File: rtl/snp_pkg.sv
package snp_pkg;

  typedef enum logic [1:0] {
    RSP_NONE = 2'b00,
    RSP_OK   = 2'b01,
    RSP_BLK  = 2'b10,
    RSP_BAD  = 2'b11
  } rsp_e;

  typedef enum logic [1:0] {
    OUT_NONE  = 2'b00,
    OUT_OK    = 2'b01,
    OUT_BLK   = 2'b10,
    OUT_RETRY = 2'b11
  } out_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'b00,
    ST_POLL    = 2'b01,
    ST_RESOLVE = 2'b10,
    ST_BLOCKED = 2'b11
  } st_e;

  localparam logic [1:0] CMD_RD = 2'b01;
  localparam logic [1:0] CMD_WR = 2'b10;

endpackage

// File: rtl/snp_poll_order.sv
module snp_poll_order #(
  parameter int                NPORTS      = 4,
  parameter logic [NPORTS-1:0] MASTER_MASK = '0,
  localparam int               IDW         = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  output logic [IDW-1:0] order_o [NPORTS]
);

  // Masters occupy the first slots, slaves the rest; both ascending.
  always_comb begin
    int k;
    k = 0;
    for (int i = 0; i < NPORTS; i++) order_o[i] = '0;
    for (int i = 0; i < NPORTS; i++) begin
      if (MASTER_MASK[i]) begin
        order_o[k] = IDW'(i);
        k = k + 1;
      end
    end
    for (int i = 0; i < NPORTS; i++) begin
      if (!MASTER_MASK[i]) begin
        order_o[k] = IDW'(i);
        k = k + 1;
      end
    end
  end

endmodule

// File: rtl/snp_accum.sv
module snp_accum
  import snp_pkg::*;
#(
  parameter int IDW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr_i,
  input  logic           smp_i,
  input  rsp_e           code_i,
  input  logic [IDW-1:0] port_i,
  output logic           have_o,
  output rsp_e           code_o,
  output logic [IDW-1:0] port_o,
  output logic           multi_o
);

  logic           have_q, have_d;
  rsp_e           code_q, code_d;
  logic [IDW-1:0] port_q, port_d;
  logic           multi_q, multi_d;
  logic           is_result;

  assign is_result = (code_i == RSP_OK) || (code_i == RSP_BLK);

  always_comb begin
    have_d  = have_q;
    code_d  = code_q;
    port_d  = port_q;
    multi_d = multi_q;
    if (clr_i) begin
      have_d  = 1'b0;
      code_d  = RSP_NONE;
      port_d  = '0;
      multi_d = 1'b0;
    end else if (smp_i && is_result) begin
      if (have_q) begin
        multi_d = 1'b1;
      end else begin
        have_d = 1'b1;
        code_d = code_i;
        port_d = port_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q  <= 1'b0;
      code_q  <= RSP_NONE;
      port_q  <= '0;
      multi_q <= 1'b0;
    end else begin
      have_q  <= have_d;
      code_q  <= code_d;
      port_q  <= port_d;
      multi_q <= multi_d;
    end
  end

  assign have_o  = have_q;
  assign code_o  = code_q;
  assign port_o  = port_q;
  assign multi_o = multi_q;

endmodule

// File: rtl/snp_resolver.sv
module snp_resolver
  import snp_pkg::*;
#(
  parameter int                NPORTS      = 4,
  parameter int                AW          = 16,
  parameter logic [NPORTS-1:0] MASTER_MASK = 4'b1010,
  localparam int               IDW         = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [IDW-1:0]      req_id,
  input  logic [1:0]          req_cmd,
  input  logic [AW-1:0]       req_addr,
  output logic                req_ready,
  output logic                poll_valid,
  output logic [IDW-1:0]      poll_port,
  output logic [1:0]          poll_cmd,
  output logic [AW-1:0]       poll_addr,
  input  logic [2*NPORTS-1:0] rsp_code,
  input  logic [NPORTS-1:0]   rsp_nack,
  input  logic                release_valid,
  input  logic [IDW-1:0]      release_id,
  output logic                done,
  output logic [1:0]          done_outcome,
  output logic [IDW-1:0]      done_responder,
  output logic                err_multi,
  output logic                err_none,
  output logic                snoop_cmpl,
  output logic [IDW-1:0]      snoop_cmpl_id,
  output logic                proto_err,
  output logic                bus_blocked,
  output logic [IDW-1:0]      blocked_id
);

  localparam logic [IDW-1:0] LAST_SLOT = IDW'(NPORTS - 1);

  st_e            st_q, st_d;
  logic [IDW-1:0] slot_q, slot_d;
  logic [IDW-1:0] rid_q, rid_d;
  logic [1:0]     cmd_q, cmd_d;
  logic [AW-1:0]  addr_q, addr_d;
  logic           nack_q, nack_d;
  logic [IDW-1:0] bid_q, bid_d;
  logic           perr_q, perr_d;

  logic [IDW-1:0] order [NPORTS];
  logic           acc_clr, acc_smp;
  logic           acc_have, acc_multi;
  rsp_e           acc_code;
  logic [IDW-1:0] acc_port;
  rsp_e           cur_code;
  logic           cur_nack;
  out_e           outcome;

  snp_poll_order #(
    .NPORTS      (NPORTS),
    .MASTER_MASK (MASTER_MASK)
  ) u_order (
    .order_o (order)
  );

  assign poll_port  = order[slot_q];
  assign poll_valid = (st_q == ST_POLL) && (poll_port != rid_q);
  assign cur_code   = rsp_e'(rsp_code[{poll_port, 1'b0} +: 2]);
  assign cur_nack   = rsp_nack[poll_port];
  assign acc_smp    = poll_valid && !cur_nack;

  snp_accum #(
    .IDW (IDW)
  ) u_accum (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (acc_clr),
    .smp_i   (acc_smp),
    .code_i  (cur_code),
    .port_i  (poll_port),
    .have_o  (acc_have),
    .code_o  (acc_code),
    .port_o  (acc_port),
    .multi_o (acc_multi)
  );

  // Outcome of the finished scan.
  always_comb begin
    if (nack_q)                  outcome = OUT_RETRY;
    else if (!acc_have)          outcome = OUT_NONE;
    else if (acc_code == RSP_BLK) outcome = OUT_BLK;
    else                         outcome = OUT_OK;
  end

  // Next-state logic.
  always_comb begin
    st_d    = st_q;
    slot_d  = slot_q;
    rid_d   = rid_q;
    cmd_d   = cmd_q;
    addr_d  = addr_q;
    nack_d  = nack_q;
    bid_d   = bid_q;
    perr_d  = perr_q;
    acc_clr = 1'b0;
    if (poll_valid && (cur_code == RSP_BAD)) perr_d = 1'b1;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          st_d    = ST_POLL;
          slot_d  = '0;
          rid_d   = req_id;
          cmd_d   = req_cmd;
          addr_d  = req_addr;
          nack_d  = 1'b0;
          acc_clr = 1'b1;
        end
      end
      ST_POLL: begin
        if (poll_valid && cur_nack) begin
          nack_d = 1'b1;
          st_d   = ST_RESOLVE;
        end else if (slot_q == LAST_SLOT) begin
          st_d = ST_RESOLVE;
        end else begin
          slot_d = slot_q + 1'b1;
        end
      end
      ST_RESOLVE: begin
        if (outcome == OUT_BLK) begin
          st_d  = ST_BLOCKED;
          bid_d = acc_port;
        end else begin
          st_d = ST_IDLE;
        end
      end
      ST_BLOCKED: begin
        if (release_valid && (release_id == bid_q)) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      slot_q <= '0;
      rid_q  <= '0;
      cmd_q  <= '0;
      addr_q <= '0;
      nack_q <= 1'b0;
      bid_q  <= '0;
      perr_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      slot_q <= slot_d;
      rid_q  <= rid_d;
      cmd_q  <= cmd_d;
      addr_q <= addr_d;
      nack_q <= nack_d;
      bid_q  <= bid_d;
      perr_q <= perr_d;
    end
  end

  assign req_ready      = (st_q == ST_IDLE);
  assign poll_cmd       = cmd_q;
  assign poll_addr      = addr_q;
  assign done           = (st_q == ST_RESOLVE);
  assign done_outcome   = outcome;
  assign done_responder = ((outcome == OUT_OK) || (outcome == OUT_BLK)) ? acc_port : '0;
  assign err_multi      = done && !nack_q && acc_multi;
  assign err_none       = done && !nack_q && !acc_have &&
                          ((cmd_q == CMD_RD) || (cmd_q == CMD_WR));
  assign snoop_cmpl     = done && ((outcome == OUT_OK) || (outcome == OUT_NONE));
  assign snoop_cmpl_id  = rid_q;
  assign proto_err      = perr_q;
  assign bus_blocked    = (st_q == ST_BLOCKED);
  assign blocked_id     = bid_q;

endmodule

// File: rtl/snp_resolver_chk.sv
module snp_resolver_chk #(
  parameter int IDW = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_ready,
  input logic [IDW-1:0] req_id,
  input logic           poll_valid,
  input logic [IDW-1:0] poll_port,
  input logic           release_valid,
  input logic [IDW-1:0] release_id,
  input logic           done,
  input logic [1:0]     done_outcome,
  input logic           err_multi,
  input logic           err_none,
  input logic           snoop_cmpl,
  input logic           proto_err,
  input logic           bus_blocked,
  input logic [IDW-1:0] blocked_id
);

  logic [IDW-1:0] seen_id_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      seen_id_q <= '0;
    else if (req_valid && req_ready) seen_id_q <= req_id;
  end

  AST_NO_SELF_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    poll_valid |-> (poll_port != seen_id_q)); // R4

  AST_RETRY_NO_CMPL: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (done_outcome == 2'b11)) |-> !snoop_cmpl); // R5

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (err_multi || err_none) |-> (done && (done_outcome != 2'b11))); // R6

  AST_BLOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_blocked && !(release_valid && (release_id == blocked_id))) |=> bus_blocked); // R8

  AST_BLOCK_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_blocked |-> !req_ready); // R8

  AST_CMPL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_cmpl |-> (done && (done_outcome[1] == 1'b0))); // R9

  AST_PROTO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11

endmodule

bind snp_resolver snp_resolver_chk #(
  .IDW (IDW)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_id        (req_id),
  .poll_valid    (poll_valid),
  .poll_port     (poll_port),
  .release_valid (release_valid),
  .release_id    (release_id),
  .done          (done),
  .done_outcome  (done_outcome),
  .err_multi     (err_multi),
  .err_none      (err_none),
  .snoop_cmpl    (snoop_cmpl),
  .proto_err     (proto_err),
  .bus_blocked   (bus_blocked),
  .blocked_id    (blocked_id)
);

// File: tb/snp_resolver_bench.sv
`timescale 1ns/1ps
module snp_resolver_bench;

  localparam int         NPORTS = 4;
  localparam int         AW     = 16;
  localparam int         IDW    = 2;
  localparam logic [3:0] MMASK  = 4'b1010;

  typedef struct packed {
    logic [1:0] id;
    logic [1:0] cmd;
    logic [7:0] codes;
    logic [3:0] nack;
    logic [1:0] out;
    logic [1:0] resp;
    logic       multi;
    logic       none;
    logic       cmpl;
    logic [2:0] lat;
  } vec_t;

  localparam int NV = 11;
  // codes are {p3,p2,p1,p0}; slot order with this mask is 1,3,0,2
  localparam vec_t TBL [NV] = '{
    {2'd0, 2'b01, 8'b00_01_00_00, 4'b0000, 2'b01, 2'd2, 1'b0, 1'b0, 1'b1, 3'd5}, // R3 single slave
    {2'd2, 2'b01, 8'b01_00_00_01, 4'b0000, 2'b01, 2'd3, 1'b1, 1'b0, 1'b1, 3'd5}, // R6 master first
    {2'd1, 2'b10, 8'b00_00_00_00, 4'b0000, 2'b00, 2'd0, 1'b0, 1'b1, 1'b1, 3'd5}, // R7 write none
    {2'd3, 2'b11, 8'b00_00_00_00, 4'b0000, 2'b00, 2'd0, 1'b0, 1'b0, 1'b1, 3'd5}, // R7 inval none
    {2'd0, 2'b01, 8'b00_00_00_01, 4'b0000, 2'b00, 2'd0, 1'b0, 1'b1, 1'b1, 3'd5}, // R4 self code
    {2'd0, 2'b01, 8'b00_01_00_00, 4'b0001, 2'b01, 2'd2, 1'b0, 1'b0, 1'b1, 3'd5}, // R4 self nack
    {2'd0, 2'b01, 8'b00_00_01_00, 4'b1000, 2'b11, 2'd0, 1'b0, 1'b0, 1'b0, 3'd3}, // R5 early nack
    {2'd3, 2'b01, 8'b00_00_00_00, 4'b0100, 2'b11, 2'd0, 1'b0, 1'b0, 1'b0, 3'd5}, // R5 last nack
    {2'd1, 2'b01, 8'b00_10_00_01, 4'b0000, 2'b01, 2'd0, 1'b1, 1'b0, 1'b1, 3'd5}, // R6 ok then blk
    {2'd3, 2'b01, 8'b00_00_01_01, 4'b0100, 2'b11, 2'd0, 1'b0, 1'b0, 1'b0, 3'd5}, // R6 hidden by nack
    {2'd1, 2'b00, 8'b01_00_00_00, 4'b0000, 2'b01, 2'd3, 1'b0, 1'b0, 1'b1, 3'd5}  // R3 master win
  };

  logic                clk;
  logic                rst_n;
  logic                req_valid;
  logic [IDW-1:0]      req_id;
  logic [1:0]          req_cmd;
  logic [AW-1:0]       req_addr;
  logic                req_ready;
  logic                poll_valid;
  logic [IDW-1:0]      poll_port;
  logic [1:0]          poll_cmd;
  logic [AW-1:0]       poll_addr;
  logic [2*NPORTS-1:0] rsp_code;
  logic [NPORTS-1:0]   rsp_nack;
  logic                release_valid;
  logic [IDW-1:0]      release_id;
  logic                done;
  logic [1:0]          done_outcome;
  logic [IDW-1:0]      done_responder;
  logic                err_multi;
  logic                err_none;
  logic                snoop_cmpl;
  logic [IDW-1:0]      snoop_cmpl_id;
  logic                proto_err;
  logic                bus_blocked;
  logic [IDW-1:0]      blocked_id;

  int n_checks = 0;
  int n_fail   = 0;

  snp_resolver #(
    .NPORTS      (NPORTS),
    .AW          (AW),
    .MASTER_MASK (MMASK)
  ) u_snp_resolver (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int slot_port(input int s);
    int k = 0;
    for (int m = 1; m >= 0; m--) begin
      for (int p = 0; p < NPORTS; p++) begin
        if (MMASK[p] == m[0]) begin
          if (k == s) return p;
          k++;
        end
      end
    end
    return 0;
  endfunction

  task automatic run_vec(input vec_t v, input int idx);
    int  cnt;
    bit  poll_ok;
    @(negedge clk);
    rsp_code  = v.codes;
    rsp_nack  = v.nack;
    req_valid = 1'b1;
    req_id    = v.id;
    req_cmd   = v.cmd;
    req_addr  = AW'(16'h1000 + idx);
    @(negedge clk);
    req_valid = 1'b0;
    cnt = 1;
    poll_ok = 1'b1;
    while (!done && cnt < 10) begin
      if (poll_valid !== (slot_port(cnt - 1) != int'(v.id))) poll_ok = 1'b0;
      if (poll_valid && (int'(poll_port) != slot_port(cnt - 1))) poll_ok = 1'b0;
      if (poll_valid && (poll_addr !== AW'(16'h1000 + idx))) poll_ok = 1'b0;
      @(negedge clk);
      cnt++;
    end
    check(poll_ok, $sformatf("R2 slot order vec %0d", idx), poll_ok, 1);
    check(cnt == int'(v.lat), $sformatf("R2/R5 latency vec %0d", idx), cnt, v.lat);
    check(done_outcome == v.out, $sformatf("R3/R5 outcome vec %0d", idx), done_outcome, v.out);
    check(done_responder == v.resp, $sformatf("R3 responder vec %0d", idx), done_responder, v.resp);
    check(err_multi == v.multi, $sformatf("R6 multi vec %0d", idx), err_multi, v.multi);
    check(err_none == v.none, $sformatf("R7 none vec %0d", idx), err_none, v.none);
    check(snoop_cmpl == v.cmpl, $sformatf("R9 cmpl vec %0d", idx), snoop_cmpl, v.cmpl);
    if (v.cmpl) check(snoop_cmpl_id == v.id, $sformatf("R9 cmpl id vec %0d", idx), snoop_cmpl_id, v.id);
    @(negedge clk);
    check(!done, $sformatf("R11 done pulse vec %0d", idx), done, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_id = '0; req_cmd = '0; req_addr = '0;
    rsp_code = '0; rsp_nack = '0;
    release_valid = 1'b0; release_id = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!done && !poll_valid && !bus_blocked && !proto_err, "R1 reset outputs", done, 0);
    check(req_ready && !err_multi && !err_none && !snoop_cmpl, "R1 reset ready", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready, "R1 ready after release", req_ready, 1);

    for (int i = 0; i < NV; i++) run_vec(TBL[i], i);

    // R8 blocked answer from master port 1
    run_vec({2'd0, 2'b01, 8'b00_00_10_00, 4'b0000, 2'b10, 2'd1, 1'b0, 1'b0, 1'b0, 3'd5}, 20);
    check(bus_blocked, "R8 enters blocked", bus_blocked, 1);
    check(blocked_id == 2'd1, "R8 blocked id", blocked_id, 1);
    check(!req_ready, "R8 not ready", req_ready, 0);
    req_valid = 1'b1; req_id = 2'd2; req_cmd = 2'b01; rsp_code = 8'b00_00_00_01;
    repeat (3) @(negedge clk);
    check(!done && !poll_valid, "R8 request ignored while blocked", done, 0);
    req_valid = 1'b0;
    release_valid = 1'b1; release_id = 2'd3;
    @(negedge clk);
    release_valid = 1'b0;
    check(bus_blocked, "R8 wrong release ignored", bus_blocked, 1);
    release_valid = 1'b1; release_id = 2'd1;
    @(negedge clk);
    release_valid = 1'b0;
    check(!bus_blocked && req_ready, "R8 release by owner", bus_blocked, 0);
    @(negedge clk);
    check(!done && !poll_valid, "R8 pending request dropped", done, 0);

    // R10 illegal code on port 3 treated as none; port 2 succeeds alone
    run_vec({2'd0, 2'b01, 8'b11_01_00_00, 4'b0000, 2'b01, 2'd2, 1'b0, 1'b0, 1'b1, 3'd5}, 21);
    check(proto_err, "R10 proto_err set", proto_err, 1);
    run_vec(TBL[0], 22);
    check(proto_err, "R10 proto_err sticky", proto_err, 1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!proto_err, "R10 cleared by reset", proto_err, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule